// File: doc/BRIEF.md
# Sensor Row Strobe Sequencer

This block produces the row control strobes an image sensor needs for each row of a frame. These are a frame sync, a row step clock, the sample and rearm strobes, a pixel reset, a side select and a calibration strobe. Software or a frame controller sets the timing fields and the row count, then pulses `start`. The sequencer latches the settings and raises the frame sync, which selects row 0. It then runs a fixed chain of segments for every row. The falling edge of the row step clock selects each row after the first. Every segment length is a programmable number of clock cycles. Each field is a low gap or a high width, so the delay between two edges is the sum of the segments that lie between them.

The chain for one row is:

1. A gap, then the sample strobe.
2. A gap, then the first pixel reset.
3. A gap, then the rearm strobe. It has the same width as the sample strobe.
4. A gap, then the side select rises.
5. Side select stays high through a lead, a second pixel reset and a trail. It therefore overlaps that reset on both sides.
6. For every row except the last: a gap, then the row step pulse.

A calibration strobe runs on its own counter and fires exactly once per frame, a programmed delay after the frame sync falls. `row_ready` tells the column logic that a row has been prepared. `frame_done` marks the end of the frame.

The state machine has these states: IDLE, SYNC, PRE, S, SGAP, RST1, RGAP, R, LRGAP, LEAD, RST2, TRAIL, CGAP and CLK. The transitions are:

- IDLE→SYNC when an accepted start arrives.
- Each state moves to the next one in this chain when its segment counter expires: SYNC→PRE→S→SGAP→RST1→RGAP→R→LRGAP→LEAD→RST2→TRAIL.
- TRAIL→CGAP when more rows remain.
- TRAIL→IDLE on the last row.
- CGAP→CLK.
- CLK→PRE.

The calibration machine has three states: OFF→WAIT on the end of the frame sync, WAIT→ON when the delay expires, and ON→OFF when the width expires.

Top module: `row_strobe_seq`

## Requirements
- R1: After reset, all strobes, `row_ready`, `frame_done` and `busy` are low and `row_idx` is 0.
- R2: `start` is accepted only while `busy` and `cfg_err` are both low. `frame_sync` is then high for `cfg_sync_w` cycles, beginning in the cycle after the edge that samples `start`.
- R3: When the frame sync falls, or when `row_step` falls, the sequencer waits `cfg_pre_gap` low cycles. The sample strobe is then high for `cfg_pulse_w` cycles.
- R4: When the sample strobe falls, the sequencer waits `cfg_s_rst_gap` low cycles. `pix_reset` is then high for `cfg_rst_w` cycles.
- R5: When the first reset falls, the sequencer waits `cfg_rst_r_gap` low cycles. The rearm strobe is then high for `cfg_pulse_w` cycles.
- R6: `side_sel` rises `cfg_r_lr_gap` cycles after the rearm strobe falls. It then stays high for `cfg_lr_lead` cycles, followed by a second `pix_reset` of `cfg_rst_w` cycles, followed by `cfg_lr_trail` cycles. The second reset never rises or falls without `side_sel` being high on both sides of that edge.
- R7: After `side_sel` falls on any row except the last, the sequencer waits `cfg_lr_clk_gap` low cycles. `row_step` is then high for `cfg_clk_w` cycles, and its fall starts the next row.
- R8: `calib_pulse` is high exactly once per frame. It rises `cfg_cal_dly` cycles after `frame_sync` falls and stays high for `cfg_cal_w` cycles.
- R9: `row_ready` is a one-cycle pulse in the last high cycle of `side_sel` on every row. In that cycle `row_idx` holds the row number, counting from 0.
- R10: `frame_done` is a one-cycle pulse in the cycle after the last row's `side_sel` falls. `busy` is high from the first sync cycle until both the row chain and the calibration strobe have finished.
- R11: `cfg_err` is high whenever any timing field or `cfg_rows` is zero. A zero lead or trail would break the side-select overlap. While `cfg_err` is high, `start` is ignored.
- R12: The settings are captured when `start` is accepted. Changes on the `cfg_*` inputs during a frame have no effect on that frame.
- R13: `start` is ignored while `busy` is high. This includes the stretch after `frame_done` during which the calibration strobe is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start request |
| cfg_sync_w | input | CW | Frame sync width |
| cfg_pre_gap | input | CW | Gap from row select to sample strobe rise |
| cfg_pulse_w | input | CW | Sample and rearm strobe width |
| cfg_s_rst_gap | input | CW | Gap from sample strobe fall to first reset rise |
| cfg_rst_w | input | CW | Pixel reset width (both pulses) |
| cfg_rst_r_gap | input | CW | Gap from first reset fall to rearm strobe rise |
| cfg_r_lr_gap | input | CW | Gap from rearm strobe fall to side select rise |
| cfg_lr_lead | input | CW | Side select high before the second reset |
| cfg_lr_trail | input | CW | Side select high after the second reset |
| cfg_lr_clk_gap | input | CW | Gap from side select fall to row step rise |
| cfg_clk_w | input | CW | Row step width |
| cfg_cal_dly | input | CW | Delay from frame sync fall to calibration rise |
| cfg_cal_w | input | CW | Calibration strobe width |
| cfg_rows | input | RW | Rows per frame |
| frame_sync | output | 1 | Frame sync strobe; its fall selects row 0 |
| row_step | output | 1 | Row step clock; its fall selects the next row |
| sample_pulse | output | 1 | Sample strobe |
| rearm_pulse | output | 1 | Rearm strobe |
| pix_reset | output | 1 | Pixel reset strobe |
| side_sel | output | 1 | Side select strobe |
| calib_pulse | output | 1 | Calibration strobe |
| row_ready | output | 1 | Row prepared, one cycle |
| row_idx | output | RW | Current row number |
| frame_done | output | 1 | Frame finished, one cycle |
| busy | output | 1 | Frame or calibration in progress |
| cfg_err | output | 1 | Settings invalid; start refused |

## Verification
The calibration strobe runs on its own counter, so it can change in the same cycle as a row strobe. The most delicate case is a calibration rise that lands on the cycle in which the sample strobe rises. A directed frame sets the calibration delay equal to the pre-sample gap to force this. Both strobes are then compared cycle by cycle against a bench timeline built from the segment sums. Random frames with small fields also make the two machines collide at many other points. A second directed frame stretches the calibration strobe past `frame_done` and pulses `start` in the cycle `frame_done` is high, to show that the still-running strobe keeps the sequencer from restarting.

// File: rtl/rss_pkg.sv
package rss_pkg;

    typedef enum logic [3:0] {
        F_SYNC, F_PRE, F_PULSE, F_SRST, F_RST, F_RSTR, F_RLR,
        F_LEAD, F_TRAIL, F_LRCLK, F_CLK, F_CALD, F_CALW
    } field_e;

    localparam int NF = 13;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SYNC, ST_PRE, ST_S, ST_SGAP, ST_RST1, ST_RGAP, ST_R,
        ST_LRGAP, ST_LEAD, ST_RST2, ST_TRAIL, ST_CGAP, ST_CLK
    } state_e;

    typedef enum logic [1:0] {
        CAL_OFF, CAL_WAIT, CAL_ON
    } cal_e;

    // which timing field sets the length of a row-chain segment
    function automatic field_e seg_field(state_e s);
        field_e f;
        unique case (s)
            ST_SYNC:  f = F_SYNC;
            ST_PRE:   f = F_PRE;
            ST_S:     f = F_PULSE;
            ST_SGAP:  f = F_SRST;
            ST_RST1:  f = F_RST;
            ST_RGAP:  f = F_RSTR;
            ST_R:     f = F_PULSE;
            ST_LRGAP: f = F_RLR;
            ST_LEAD:  f = F_LEAD;
            ST_RST2:  f = F_RST;
            ST_TRAIL: f = F_TRAIL;
            ST_CGAP:  f = F_LRCLK;
            ST_CLK:   f = F_CLK;
            default:  f = F_SYNC;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rss_seg_timer.sv
module rss_seg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);

    // R11: settings are validated before use, so no zero-length segment is loaded
    a_r11_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/rss_cfg_check.sv
module rss_cfg_check #(
    parameter int NF = 13,
    parameter int CW = 8,
    parameter int RW = 8
) (
    input  logic [NF-1:0][CW-1:0] fields,
    input  logic [RW-1:0]         rows,
    output logic                  bad
);

    logic [NF-1:0] zero_f;

    for (genvar i = 0; i < NF; i++) begin : g_zero
        assign zero_f[i] = (fields[i] == '0);
    end

    assign bad = (|zero_f) || (rows == '0);

endmodule

// File: rtl/rss_cal_gen.sv
module rss_cal_gen #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [CW-1:0] dly,
    input  logic [CW-1:0] wid,
    output logic          cal,
    output logic          active
);
    import rss_pkg::*;

    cal_e          cs, cs_nxt;
    logic          t_load;
    logic [CW-1:0] t_len;
    logic          t_exp;

    rss_seg_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .len     (t_len),
        .expired (t_exp)
    );

    always_comb begin
        cs_nxt = cs;
        t_load = 1'b0;
        t_len  = dly;
        unique case (cs)
            CAL_OFF: if (trig) begin
                cs_nxt = CAL_WAIT;
                t_load = 1'b1;
                t_len  = dly;
            end
            CAL_WAIT: if (t_exp) begin
                cs_nxt = CAL_ON;
                t_load = 1'b1;
                t_len  = wid;
            end
            CAL_ON: if (t_exp) begin
                cs_nxt = CAL_OFF;
            end
            default: cs_nxt = CAL_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs <= CAL_OFF;
        else        cs <= cs_nxt;
    end

    always_comb begin
        cal    = (cs == CAL_ON);
        active = (cs != CAL_OFF);
    end

    // R8: one calibration strobe per frame, never retriggered while running
    a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (cs == CAL_OFF));

endmodule

// File: rtl/row_strobe_seq.sv
module row_strobe_seq
    import rss_pkg::*;
#(
    parameter int CW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_sync_w,
    input  logic [CW-1:0] cfg_pre_gap,
    input  logic [CW-1:0] cfg_pulse_w,
    input  logic [CW-1:0] cfg_s_rst_gap,
    input  logic [CW-1:0] cfg_rst_w,
    input  logic [CW-1:0] cfg_rst_r_gap,
    input  logic [CW-1:0] cfg_r_lr_gap,
    input  logic [CW-1:0] cfg_lr_lead,
    input  logic [CW-1:0] cfg_lr_trail,
    input  logic [CW-1:0] cfg_lr_clk_gap,
    input  logic [CW-1:0] cfg_clk_w,
    input  logic [CW-1:0] cfg_cal_dly,
    input  logic [CW-1:0] cfg_cal_w,
    input  logic [RW-1:0] cfg_rows,
    output logic          frame_sync,
    output logic          row_step,
    output logic          sample_pulse,
    output logic          rearm_pulse,
    output logic          pix_reset,
    output logic          side_sel,
    output logic          calib_pulse,
    output logic          row_ready,
    output logic [RW-1:0] row_idx,
    output logic          frame_done,
    output logic          busy,
    output logic          cfg_err
);

    logic [NF-1:0][CW-1:0] cfg_live, cfg_q;
    logic [RW-1:0]         rows_q, row_q;
    state_e                st, st_nxt;
    field_e                fsel;
    logic [CW-1:0]         seg_len;
    logic                  seg_exp, seg_end, adv, go, last_row;
    logic                  cal_trig, cal_active, done_q;

    always_comb begin
        cfg_live[F_SYNC]  = cfg_sync_w;
        cfg_live[F_PRE]   = cfg_pre_gap;
        cfg_live[F_PULSE] = cfg_pulse_w;
        cfg_live[F_SRST]  = cfg_s_rst_gap;
        cfg_live[F_RST]   = cfg_rst_w;
        cfg_live[F_RSTR]  = cfg_rst_r_gap;
        cfg_live[F_RLR]   = cfg_r_lr_gap;
        cfg_live[F_LEAD]  = cfg_lr_lead;
        cfg_live[F_TRAIL] = cfg_lr_trail;
        cfg_live[F_LRCLK] = cfg_lr_clk_gap;
        cfg_live[F_CLK]   = cfg_clk_w;
        cfg_live[F_CALD]  = cfg_cal_dly;
        cfg_live[F_CALW]  = cfg_cal_w;
    end

    rss_cfg_check #(.NF(NF), .CW(CW), .RW(RW)) u_chk (
        .fields (cfg_live),
        .rows   (cfg_rows),
        .bad    (cfg_err)
    );

    assign go       = start && !busy && !cfg_err;
    assign seg_end  = seg_exp && (st != ST_IDLE);
    assign last_row = (row_q == rows_q - RW'(1));

    // next-state selection
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (go)      st_nxt = ST_SYNC;
            ST_SYNC:  if (seg_end) st_nxt = ST_PRE;
            ST_PRE:   if (seg_end) st_nxt = ST_S;
            ST_S:     if (seg_end) st_nxt = ST_SGAP;
            ST_SGAP:  if (seg_end) st_nxt = ST_RST1;
            ST_RST1:  if (seg_end) st_nxt = ST_RGAP;
            ST_RGAP:  if (seg_end) st_nxt = ST_R;
            ST_R:     if (seg_end) st_nxt = ST_LRGAP;
            ST_LRGAP: if (seg_end) st_nxt = ST_LEAD;
            ST_LEAD:  if (seg_end) st_nxt = ST_RST2;
            ST_RST2:  if (seg_end) st_nxt = ST_TRAIL;
            ST_TRAIL: if (seg_end) st_nxt = last_row ? ST_IDLE : ST_CGAP;
            ST_CGAP:  if (seg_end) st_nxt = ST_CLK;
            ST_CLK:   if (seg_end) st_nxt = ST_PRE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    assign adv     = (st_nxt != st);
    assign fsel    = seg_field(st_nxt);
    assign seg_len = (st == ST_IDLE) ? cfg_live[fsel] : cfg_q[fsel];

    rss_seg_timer #(.CW(CW)) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (adv && (st_nxt != ST_IDLE)),
        .len     (seg_len),
        .expired (seg_exp)
    );

    // state register, settings snapshot, row counter, end-of-frame flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cfg_q  <= '0;
            rows_q <= '0;
            row_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            done_q <= (st == ST_TRAIL) && seg_end && last_row;
            if (go) begin
                cfg_q  <= cfg_live;
                rows_q <= cfg_rows;
                row_q  <= '0;
            end else if ((st == ST_CLK) && seg_end) begin
                row_q <= row_q + RW'(1);
            end
        end
    end

    assign cal_trig = (st == ST_SYNC) && seg_end;

    rss_cal_gen #(.CW(CW)) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (cal_trig),
        .dly    (cfg_q[F_CALD]),
        .wid    (cfg_q[F_CALW]),
        .cal    (calib_pulse),
        .active (cal_active)
    );

    // output decode
    always_comb begin
        frame_sync   = (st == ST_SYNC);
        sample_pulse = (st == ST_S);
        rearm_pulse  = (st == ST_R);
        pix_reset    = (st == ST_RST1) || (st == ST_RST2);
        side_sel     = (st == ST_LEAD) || (st == ST_RST2) || (st == ST_TRAIL);
        row_step     = (st == ST_CLK);
        row_ready    = (st == ST_TRAIL) && seg_end;
        row_idx      = row_q;
        frame_done   = done_q;
        busy         = (st != ST_IDLE) || cal_active;
    end

    // R6: side select is already high when the second reset rises
    a_r6_lr_leads_rst: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pix_reset) && side_sel) |-> $past(side_sel));

    // R6: side select stays high after the second reset falls
    a_r6_lr_trails_rst: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pix_reset) && $past(side_sel)) |-> side_sel);

    // R9: row ready only inside the side select window
    a_r9_ready_in_lr: assert property (@(posedge clk) disable iff (!rst_n)
        row_ready |-> side_sel);

    // R2: the frame sync only ever precedes row 0
    a_r2_sync_row0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> (row_idx == '0));

    // R13: a start while busy never opens a new frame
    a_r13_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !$rose(frame_sync));

    // R11: invalid settings keep the sequencer idle
    a_r11_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_err && !busy) |=> !busy);

    // R10: the end flag comes with all row strobes quiet
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!side_sel && !frame_sync && !sample_pulse));

endmodule

// File: tb/tb_row_strobe_seq.sv
`timescale 1ns/1ps
module tb_row_strobe_seq;
    import rss_pkg::*;

    localparam int CW = 8;
    localparam int RW = 8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [CW-1:0] cfg_sync_w, cfg_pre_gap, cfg_pulse_w, cfg_s_rst_gap, cfg_rst_w;
    logic [CW-1:0] cfg_rst_r_gap, cfg_r_lr_gap, cfg_lr_lead, cfg_lr_trail;
    logic [CW-1:0] cfg_lr_clk_gap, cfg_clk_w, cfg_cal_dly, cfg_cal_w;
    logic [RW-1:0] cfg_rows;
    logic frame_sync, row_step, sample_pulse, rearm_pulse, pix_reset, side_sel;
    logic calib_pulse, row_ready, frame_done, busy, cfg_err;
    logic [RW-1:0] row_idx;

    int n_chk = 0, n_fail = 0;
    int m_f[NF];
    int m_rows;
    int exp_ridx;
    bit exp_rdy_valid;

    always #4 clk = ~clk;

    row_strobe_seq #(.CW(CW), .RW(RW)) dut (.*);

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_cfg();
        cfg_sync_w     = CW'(m_f[F_SYNC]);
        cfg_pre_gap    = CW'(m_f[F_PRE]);
        cfg_pulse_w    = CW'(m_f[F_PULSE]);
        cfg_s_rst_gap  = CW'(m_f[F_SRST]);
        cfg_rst_w      = CW'(m_f[F_RST]);
        cfg_rst_r_gap  = CW'(m_f[F_RSTR]);
        cfg_r_lr_gap   = CW'(m_f[F_RLR]);
        cfg_lr_lead    = CW'(m_f[F_LEAD]);
        cfg_lr_trail   = CW'(m_f[F_TRAIL]);
        cfg_lr_clk_gap = CW'(m_f[F_LRCLK]);
        cfg_clk_w      = CW'(m_f[F_CLK]);
        cfg_cal_dly    = CW'(m_f[F_CALD]);
        cfg_cal_w      = CW'(m_f[F_CALW]);
        cfg_rows       = RW'(m_rows);
    endtask

    task automatic scramble_cfg();
        cfg_sync_w = CW'($urandom);     cfg_pre_gap = CW'($urandom);
        cfg_pulse_w = CW'($urandom);    cfg_s_rst_gap = CW'($urandom);
        cfg_rst_w = CW'($urandom);      cfg_rst_r_gap = CW'($urandom);
        cfg_r_lr_gap = CW'($urandom);   cfg_lr_lead = CW'($urandom_range(0, 1));
        cfg_lr_trail = CW'($urandom);   cfg_lr_clk_gap = CW'($urandom);
        cfg_clk_w = CW'($urandom);      cfg_cal_dly = CW'($urandom);
        cfg_cal_w = CW'($urandom);      cfg_rows = RW'($urandom);
    endtask

    function automatic bit inw(int t, int p, int len);
        return (t >= p) && (t < p + len);
    endfunction

    function automatic int frame_end();
        int p = m_f[F_SYNC];
        for (int r = 0; r < m_rows; r++) begin
            p += m_f[F_PRE] + m_f[F_PULSE] + m_f[F_SRST] + m_f[F_RST] + m_f[F_RSTR]
               + m_f[F_PULSE] + m_f[F_RLR] + m_f[F_LEAD] + m_f[F_RST] + m_f[F_TRAIL];
            if (r != m_rows - 1) p += m_f[F_LRCLK] + m_f[F_CLK];
        end
        return p;
    endfunction

    function automatic int cal_end();
        return m_f[F_SYNC] + m_f[F_CALD] + m_f[F_CALW];
    endfunction

    // expected {sync,s,r,rst,lr,clk,cal,ready,done,busy} in cycle t after the start edge
    function automatic logic [9:0] model(int t);
        logic [9:0] v = '0;
        int p = m_f[F_SYNC];
        int lrlen;
        exp_rdy_valid = 1'b0;
        if (t < m_f[F_SYNC]) v[9] = 1'b1;
        if (inw(t, m_f[F_SYNC] + m_f[F_CALD], m_f[F_CALW])) v[3] = 1'b1;
        for (int r = 0; r < m_rows; r++) begin
            p += m_f[F_PRE];
            if (inw(t, p, m_f[F_PULSE])) v[8] = 1'b1;
            p += m_f[F_PULSE] + m_f[F_SRST];
            if (inw(t, p, m_f[F_RST])) v[6] = 1'b1;
            p += m_f[F_RST] + m_f[F_RSTR];
            if (inw(t, p, m_f[F_PULSE])) v[7] = 1'b1;
            p += m_f[F_PULSE] + m_f[F_RLR];
            lrlen = m_f[F_LEAD] + m_f[F_RST] + m_f[F_TRAIL];
            if (inw(t, p, lrlen)) v[5] = 1'b1;
            if (inw(t, p + m_f[F_LEAD], m_f[F_RST])) v[6] = 1'b1;
            if (t == p + lrlen - 1) begin
                v[2] = 1'b1;
                exp_ridx = r;
                exp_rdy_valid = 1'b1;
            end
            p += lrlen;
            if (r != m_rows - 1) begin
                p += m_f[F_LRCLK];
                if (inw(t, p, m_f[F_CLK])) v[4] = 1'b1;
                p += m_f[F_CLK];
            end
        end
        if (t == p) v[1] = 1'b1;
        if (t < ((p > cal_end()) ? p : cal_end())) v[0] = 1'b1;
        return v;
    endfunction

    // runs one frame from the current m_* settings and compares every cycle
    task automatic run_frame(string tag, bit scramble, int inject_t);
        string names[10] = '{"frame_sync R2", "sample R3", "rearm R5", "pix_reset R4/R6",
                             "side_sel R6", "row_step R7", "calib R8", "row_ready R9",
                             "frame_done R10", "busy R10"};
        int errs[10];
        int fa[10], fe[10], ft[10];
        int tot, ridx_err = 0, any_err = 0;
        logic [9:0] ev, av;
        foreach (errs[i]) begin errs[i] = 0; fa[i] = 0; fe[i] = 0; ft[i] = 0; end
        tot = (frame_end() > cal_end()) ? frame_end() : cal_end();
        drive_cfg();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) scramble_cfg();
        for (int t = 0; t <= tot + 2; t++) begin
            ev = model(t);
            av = {frame_sync, sample_pulse, rearm_pulse, pix_reset, side_sel,
                  row_step, calib_pulse, row_ready, frame_done, busy};
            for (int b = 0; b < 10; b++) begin
                if (av[9-b] !== ev[9-b]) begin
                    if (errs[b] == 0) begin fa[b] = av[9-b]; fe[b] = ev[9-b]; ft[b] = t; end
                    errs[b]++;
                    any_err++;
                end
            end
            if (exp_rdy_valid && (int'(row_idx) != exp_ridx)) ridx_err++;
            start = (t == inject_t);
            @(negedge clk);
        end
        start = 1'b0;
        for (int b = 0; b < 10; b++)
            check(errs[b] == 0, names[b], $sformatf("%s first mismatch cycle %0d", tag, ft[b]),
                  fa[b], fe[b]);
        check(ridx_err == 0, "R9", {tag, " row_idx mismatches"}, ridx_err, 0);
        if (scramble) check(any_err == 0, "R12", {tag, " mid-frame setting change"}, any_err, 0);
        if (inject_t >= 0) check(any_err == 0, "R13", {tag, " start while busy"}, any_err, 0);
        drive_cfg();
    endtask

    task automatic set_base();
        foreach (m_f[i]) m_f[i] = 2;
        m_rows = 3;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        report();
    end

    initial begin : main
        int p;
        void'($urandom(32'd20240611));
        set_base();
        drive_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check({frame_sync, row_step, sample_pulse, rearm_pulse, pix_reset, side_sel,
               calib_pulse, row_ready, frame_done, busy} == '0, "R1", "strobes after reset",
              int'({frame_sync, sample_pulse, pix_reset, side_sel, busy}), 0);
        check(row_idx == '0, "R1", "row_idx after reset", int'(row_idx), 0);
        check(cfg_err == 1'b0, "R11", "valid settings flag", int'(cfg_err), 0);

        // R11: zero lead refused
        m_f[F_LEAD] = 0;
        drive_cfg();
        @(negedge clk);
        check(cfg_err == 1'b1, "R11", "zero lead flag", int'(cfg_err), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && !frame_sync, "R11", "zero lead start refused", int'(busy), 0);
        // R11: zero trail refused
        m_f[F_LEAD] = 2;
        m_f[F_TRAIL] = 0;
        drive_cfg();
        @(negedge clk);
        check(cfg_err == 1'b1, "R11", "zero trail flag", int'(cfg_err), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && !frame_sync, "R11", "zero trail start refused", int'(busy), 0);
        // R11: zero row count refused
        m_f[F_TRAIL] = 2;
        m_rows = 0;
        drive_cfg();
        @(negedge clk);
        check(cfg_err == 1'b1, "R11", "zero rows flag", int'(cfg_err), 1);
        set_base();
        drive_cfg();

        // plain frame
        run_frame("base", 1'b0, -1);

        // calibration rise lands on the sample rise (R8 with R3)
        set_base();
        m_f[F_PRE] = 3;
        m_f[F_CALD] = 3;
        m_f[F_CALW] = 4;
        run_frame("cal_on_sample", 1'b0, -1);

        // all-ones minimum timing, single row
        foreach (m_f[i]) m_f[i] = 1;
        m_rows = 1;
        run_frame("minimum", 1'b0, -1);

        // calibration outlives the frame; start during frame_done (R13)
        set_base();
        m_rows = 1;
        m_f[F_CALD] = 200;
        p = frame_end();
        run_frame("cal_tail", 1'b0, p);

        // random frames
        for (int k = 0; k < 30; k++) begin
            bit scr;
            int inj;
            foreach (m_f[i]) m_f[i] = 1 + $urandom_range(0, 4);
            m_rows = 1 + $urandom_range(0, 3);
            scr = $urandom_range(0, 1);
            inj = -1;
            if ($urandom_range(0, 1) == 1) inj = $urandom_range(1, frame_end() - 1);
            run_frame($sformatf("rand%0d", k), scr, inj);
        end

        report();
    end

endmodule